// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block produces one high pulse on its output for each accepted trigger. The pulse length is a 16-bit count multiplied by the period of a selectable count source. The count source is the system clock divided by 2, 16, 64 or 512. A mode byte chooses the trigger source: a software strobe or an external pin. For the pin it also chooses the active edge and the division ratio. A count-start bit gates the whole function. When the count runs out, the output falls, the counter is reloaded from its reload register, and a one-cycle interrupt request is raised.

A trigger that arrives while a pulse is running restarts the pulse from the reload value. A data write has two behaviours. While the timer is halted it loads both the reload register and the counter. While the timer is busy it only changes the reload register, and the new value takes effect at the next reload. The external pin passes through a two-flop synchronizer before its edges are detected.

Top module: `oneshot_timer`

## Requirements
- R1: The timer works only when mode bits [2:0] are 3'b110 and mode bit 5 is 0. Any other mode byte keeps the output low and ignores triggers.
- R2: Mode bits [7:6] select the count-source divisor: 0 gives 2, 1 gives 16, 2 gives 64, 3 gives 512. A pulse started from a count of N stays high for exactly N times the divisor clock cycles.
- R3: Mode bit 4 selects the trigger source. At 0 only the software strobe `swTrig` triggers. At 1 only an edge on `trigPin` triggers.
- R4: Mode bit 3 selects the pin edge. At 0 only a falling edge triggers. At 1 only a rising edge triggers.
- R5: While the count-start bit is 0, triggers are ignored. Clearing the bit drives the output low on the next cycle, even in the middle of a pulse, and no interrupt follows.
- R6: At the end of a pulse the output falls and `irqPulse` is high for exactly one cycle. The counter is reloaded, so the next trigger repeats the reload value.
- R7: A trigger during a pulse reloads the counter and restarts the count source. The total high time becomes the cycles already spent plus the full reload length.
- R8: A retrigger that arrives before one count-source tick has passed since the last accepted trigger is ignored.
- R9: A data write while the timer is halted loads both the counter and the reload register. A data write while busy changes only the reload register, and the running pulse keeps its length.
- R10: A trigger that finds the counter at zero does not raise the output and does not raise an interrupt.
- R11: When a retrigger lands in the same cycle as the final tick, the retrigger wins. The pulse continues and that final tick raises no interrupt.
- R12: During and right after reset, `pulseOut` and `irqPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWe | input | 1 | Mode byte write strobe |
| modeData | input | 8 | Mode byte value |
| startWe | input | 1 | Count-start bit write strobe |
| startData | input | 1 | Count-start bit value |
| swTrig | input | 1 | Software trigger strobe |
| trigPin | input | 1 | External trigger pin (asynchronous) |
| dataWe | input | 1 | Count value write strobe |
| dataIn | input | 16 | Count value |
| pulseOut | output | 1 | One-shot pulse output |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
Two events can land in the same clock cycle: a retrigger and the final count-source tick of the running pulse. The bench sets this up with a count of 2 at divisor 2. It places the software strobe exactly on the edge where the counter leaves 1. It then checks that the high time equals the four elapsed cycles plus a full new pulse, and that only the later, genuine end raises the interrupt. A busy-time data write that coincides with a pulse is judged from two results: the length of the current pulse, which must be unchanged, and the length of the next one, which must use the new value.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic clrPsc;   // restart the count-source prescaler
    logic loadCnt;  // copy reload register into the counter
    logic decCnt;   // decrement the counter by one
  } dpCtl_t;

  // Low three mode bits that enable one-shot operation.
  localparam logic [2:0] MODE_KEY = 3'b110;
endpackage

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIV0_LOG2 = 1,
  parameter int DIV1_LOG2 = 4,
  parameter int DIV2_LOG2 = 6,
  parameter int DIV3_LOG2 = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             busy,
  input  logic [1:0]       divSel,
  input  logic             dataWe,
  input  logic [CNT_W-1:0] dataIn,
  output logic             tick,
  output logic [CNT_W-1:0] cntVal
);
  localparam int PSC_W = DIV3_LOG2;

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] pscLimit;
  logic [CNT_W-1:0] reloadReg;

  always_comb begin
    case (divSel)
      2'd0:    pscLimit = PSC_W'((1 << DIV0_LOG2) - 1);
      2'd1:    pscLimit = PSC_W'((1 << DIV1_LOG2) - 1);
      2'd2:    pscLimit = PSC_W'((1 << DIV2_LOG2) - 1);
      default: pscLimit = PSC_W'((1 << DIV3_LOG2) - 1);
    endcase
  end

  assign tick = busy && (psc == pscLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psc <= '0;
    end else if (ctl.clrPsc) begin
      psc <= '0;
    end else if (busy) begin
      psc <= (psc == pscLimit) ? '0 : psc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
      cntVal    <= '0;
    end else begin
      if (dataWe) reloadReg <= dataIn;
      if (ctl.loadCnt)           cntVal <= reloadReg;
      else if (ctl.decCnt)       cntVal <= cntVal - 1'b1;
      else if (dataWe && !busy)  cntVal <= dataIn;
    end
  end
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWe,
  input  logic [7:0]       modeData,
  input  logic             startWe,
  input  logic             startData,
  input  logic             swTrig,
  input  logic             trigPin,
  input  logic             tick,
  input  logic [CNT_W-1:0] cntVal,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             pulseOut,
  output logic             irqPulse,
  output logic [1:0]       divSel
);
  logic [7:0]        modeReg;
  logic              runOn;
  logic [SYNC_N-1:0] syncQ;
  logic              pinPrev;
  logic              tickSeen;

  logic modeOk, active, extSel, riseSel, pinEdge, trigEvt;
  logic cntZero, cntOne, startIdle, retrig, terminal;

  always_comb begin
    modeOk    = (modeReg[2:0] == MODE_KEY) && !modeReg[5];
    active    = modeOk && runOn;
    extSel    = modeReg[4];
    riseSel   = modeReg[3];
    divSel    = modeReg[7:6];
    pinEdge   = riseSel ? (syncQ[SYNC_N-1] && !pinPrev)
                        : (!syncQ[SYNC_N-1] && pinPrev);
    trigEvt   = active && (extSel ? pinEdge : swTrig);
    cntZero   = (cntVal == '0);
    cntOne    = (cntVal == CNT_W'(1));
    startIdle = trigEvt && !busy && !cntZero;
    retrig    = trigEvt && busy && tickSeen;
    terminal  = busy && tick && cntOne;
    ctl.clrPsc  = startIdle || retrig;
    ctl.loadCnt = retrig || terminal;
    ctl.decCnt  = busy && tick && !cntOne && !retrig;
    pulseOut    = busy && active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      runOn    <= 1'b0;
      syncQ    <= '0;
      pinPrev  <= 1'b0;
      tickSeen <= 1'b0;
      busy     <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (modeWe)  modeReg <= modeData;
      if (startWe) runOn   <= startData;
      syncQ   <= {syncQ[SYNC_N-2:0], trigPin};
      pinPrev <= syncQ[SYNC_N-1];

      if (startIdle || retrig) tickSeen <= 1'b0;
      else if (tick)           tickSeen <= 1'b1;

      if (!active)                busy <= 1'b0;
      else if (startIdle||retrig) busy <= 1'b1;
      else if (terminal)          busy <= 1'b0;

      irqPulse <= active && terminal && !retrig;
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_N    = 2,
  parameter int DIV0_LOG2 = 1,
  parameter int DIV1_LOG2 = 4,
  parameter int DIV2_LOG2 = 6,
  parameter int DIV3_LOG2 = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWe,
  input  logic [7:0]       modeData,
  input  logic             startWe,
  input  logic             startData,
  input  logic             swTrig,
  input  logic             trigPin,
  input  logic             dataWe,
  input  logic [CNT_W-1:0] dataIn,
  output logic             pulseOut,
  output logic             irqPulse
);
  dpCtl_t           ctl;
  logic             busy;
  logic             tick;
  logic [1:0]       divSel;
  logic [CNT_W-1:0] cntVal;

  oneshot_ctrl #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeData(modeData),
    .startWe(startWe), .startData(startData), .swTrig(swTrig),
    .trigPin(trigPin), .tick(tick), .cntVal(cntVal), .ctl(ctl),
    .busy(busy), .pulseOut(pulseOut), .irqPulse(irqPulse), .divSel(divSel)
  );

  oneshot_dp #(
    .CNT_W(CNT_W), .DIV0_LOG2(DIV0_LOG2), .DIV1_LOG2(DIV1_LOG2),
    .DIV2_LOG2(DIV2_LOG2), .DIV3_LOG2(DIV3_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .divSel(divSel),
    .dataWe(dataWe), .dataIn(dataIn), .tick(tick), .cntVal(cntVal)
  );
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeWe,
  input logic [7:0]       modeData,
  input logic             startWe,
  input logic             startData,
  input logic             pulseOut,
  input logic             irqPulse,
  input logic [CNT_W-1:0] cntVal
);
  AST_INVALID_MODE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && ((modeData[2:0] != 3'b110) || modeData[5])) |=> !pulseOut); // R1

  AST_STOP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (startWe && !startData) |=> !pulseOut); // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R6

  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (!pulseOut && $past(pulseOut))); // R6

  AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> ($past(cntVal) != '0)); // R10
endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeData(modeData),
  .startWe(startWe), .startData(startData), .pulseOut(pulseOut),
  .irqPulse(irqPulse), .cntVal(cntVal)
);

// File: tb/test_oneshot_timer.sv
`timescale 1ns/1ps
module test_oneshot_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWe = 1'b0, startWe = 1'b0, startData = 1'b0;
  logic        swTrig = 1'b0, trigPin = 1'b1, dataWe = 1'b0;
  logic [7:0]  modeData = '0;
  logic [15:0] dataIn = '0;
  logic        pulseOut, irqPulse;

  int nChecks = 0, nFail = 0;
  int highCnt = 0, irqCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  oneshot_timer i_oneshot_timer (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeData(modeData),
    .startWe(startWe), .startData(startData), .swTrig(swTrig),
    .trigPin(trigPin), .dataWe(dataWe), .dataIn(dataIn),
    .pulseOut(pulseOut), .irqPulse(irqPulse)
  );

  always @(negedge clk) if (rstN) begin
    if (pulseOut) highCnt++;
    if (irqPulse) irqCnt++;
  end

  typedef struct packed {
    logic [7:0]  mode;
    logic [15:0] cnt;
    logic [31:0] width;
  } vec_t;

  // R2: divisor selected by mode bits [7:6]
  localparam vec_t VECS [5] = '{
    '{8'h06, 16'd5,   32'd10},
    '{8'h46, 16'd3,   32'd48},
    '{8'h86, 16'd2,   32'd128},
    '{8'hC6, 16'd1,   32'd512},
    '{8'h06, 16'd300, 32'd600}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tickUp(); @(posedge clk); #2; endtask
  task automatic waitCyc(input int n); repeat (n) @(posedge clk); #2; endtask

  task automatic writeMode(input logic [7:0] m);
    tickUp(); modeWe = 1'b1; modeData = m; tickUp(); modeWe = 1'b0;
  endtask
  task automatic writeStart(input logic b);
    tickUp(); startWe = 1'b1; startData = b; tickUp(); startWe = 1'b0;
  endtask
  task automatic writeData(input logic [15:0] d);
    tickUp(); dataWe = 1'b1; dataIn = d; tickUp(); dataWe = 1'b0;
  endtask
  task automatic swPulse();
    tickUp(); swTrig = 1'b1; tickUp(); swTrig = 1'b0;
  endtask
  task automatic clearMon(); highCnt = 0; irqCnt = 0; endtask

  initial begin
    #(150000 * 8);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 pulse in reset", int'(pulseOut), 0);
    check("R12 irq in reset", int'(irqPulse), 0);
    tickUp(); rstN = 1'b1;
    @(negedge clk);
    check("R12 pulse after reset", int'(pulseOut), 0);
    check("R12 irq after reset", int'(irqPulse), 0);

    writeStart(1'b1);
    // R2 table walk
    foreach (VECS[i]) begin
      writeMode(VECS[i].mode);
      writeData(VECS[i].cnt);
      tickUp(); clearMon();
      swPulse();
      waitCyc(int'(VECS[i].width) + 12);
      check($sformatf("R2 width vec%0d", i), highCnt, int'(VECS[i].width));
      check($sformatf("R6 irq vec%0d", i), irqCnt, 1);
    end

    // R1: invalid modes
    writeMode(8'h07); writeData(16'd5); clearMon(); swPulse(); waitCyc(30);
    check("R1 low bit pattern", highCnt, 0);
    writeMode(8'h26); clearMon(); swPulse(); waitCyc(30);
    check("R1 bit5 set", highCnt + irqCnt, 0);
    writeMode(8'h06);

    // R10: zero count
    writeData(16'd0); clearMon(); swPulse(); waitCyc(30);
    check("R10 zero high", highCnt, 0);
    check("R10 zero irq", irqCnt, 0);

    // R9: busy write keeps pulse, next pulse uses new value (R6 reload)
    writeData(16'd4); clearMon(); swPulse(); waitCyc(2);
    writeData(16'd6); waitCyc(20);
    check("R9 busy write width", highCnt, 8);
    clearMon(); swPulse(); waitCyc(30);
    check("R6 reload next width", highCnt, 12);
    check("R6 reload next irq", irqCnt, 1);
    writeData(16'd3); clearMon(); swPulse(); waitCyc(20);
    check("R9 halted write width", highCnt, 6);

    // R7: retrigger sampled 7 cycles after the first trigger
    writeData(16'd10); clearMon(); swPulse();
    repeat (6) @(posedge clk); #2; swTrig = 1'b1; tickUp(); swTrig = 1'b0;
    waitCyc(40);
    check("R7 retrigger width", highCnt, 27);
    check("R7 retrigger irq", irqCnt, 1);

    // R8: retrigger one cycle after trigger is ignored
    clearMon(); tickUp(); swTrig = 1'b1; tickUp(); tickUp(); swTrig = 1'b0;
    waitCyc(40);
    check("R8 early retrigger width", highCnt, 20);

    // R11: retrigger on the final tick
    writeData(16'd2); clearMon(); swPulse();
    repeat (3) @(posedge clk); #2; swTrig = 1'b1; tickUp(); swTrig = 1'b0;
    waitCyc(20);
    check("R11 collision width", highCnt, 8);
    check("R11 collision irq", irqCnt, 1);

    // R5: stopping mid-pulse, then triggers ignored
    writeData(16'd50); clearMon(); swPulse(); waitCyc(5);
    writeStart(1'b0);
    @(negedge clk);
    check("R5 output low after stop", int'(pulseOut), 0);
    waitCyc(150);
    check("R5 no irq after stop", irqCnt, 0);
    clearMon(); swPulse(); waitCyc(20);
    check("R5 trigger while stopped", highCnt, 0);
    writeStart(1'b1);

    // R3/R4: pin trigger, falling edge
    writeMode(8'h16); writeData(16'd3); clearMon(); swPulse(); waitCyc(20);
    check("R3 strobe ignored in pin mode", highCnt, 0);
    tickUp(); trigPin = 1'b0; waitCyc(20);
    check("R4 falling edge width", highCnt, 6);
    // R4: rising edge
    writeMode(8'h1E); clearMon();
    tickUp(); trigPin = 1'b1; waitCyc(20);
    check("R4 rising edge width", highCnt, 6);
    clearMon(); tickUp(); trigPin = 1'b0; waitCyc(20);
    check("R4 falling ignored in rising mode", highCnt, 0);
    // R3: pin ignored in software mode
    writeMode(8'h06); clearMon(); tickUp(); trigPin = 1'b1; waitCyc(5);
    trigPin = 1'b0; waitCyc(20);
    check("R3 pin ignored in strobe mode", highCnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule